// File: doc/BRIEF.md
# Strided Vector Slice Address Generator

This block turns one vector memory request into bank-parallel access beats for a sixteen-bank second-level cache. A request names a quadword base address, a signed stride in quadwords and an element count of up to 128. Each output beat carries sixteen lane addresses with a lane-valid mask. The lane number is the cache bank that the address targets, so no two lanes of one beat can collide.

The stride picks one of three routes. A stride of one takes the double-rate line route: four beats of whole-line requests covering every line the vector touches. A stride of zero, or any odd stride, takes the quadword-slice route: eight slices of sixteen elements. Within a slice, elements are placed on lanes by the bank they hit, using a small computed table of multiplicative inverses modulo the bank count. Every other stride (even and non-zero) revisits a bank within sixteen elements. Such a request is passed unchanged to a gather/scatter port and produces no slices.

The controller is a four-state machine. `ST_IDLE` accepts a request and branches by class: to `ST_SLICE` for quadword slices, to `ST_LINE` for line beats, or to `ST_HANDOFF` for the gather/scatter port. `ST_SLICE` returns to `ST_IDLE` when its eighth slice is taken. `ST_LINE` returns after its fourth beat is taken. `ST_HANDOFF` returns once the gather/scatter port takes the request.

Top module: `vslice_gen`

## Requirements
- R1: Requests are routed by stride. A stride of 1 gives line beats (`out_line`=1). A stride of 0 or an odd stride gives quadword slices (`out_line`=0). An even non-zero stride produces no beats and appears on the gather/scatter port with base, stride and length unchanged.
- R2: A quadword-slice request yields exactly 8 beats whatever its length. `out_last` is set on the eighth beat only, and `req_ready` rises in the cycle after that beat is taken.
- R3: With a non-zero stride, slice k (0 to 7) carries elements 16k to 16k+15, each exactly once. Element i sits on the lane equal to bits [3:0] of its address, which is base + i*stride modulo 2^32 (stride sign-extended from 16 bits). Every lane carries its address even when masked.
- R4: In a quadword slice, a lane's mask bit is set exactly when its element index is below the vector length. A length of 0 gives all-zero masks in all 8 slices.
- R5: With stride 0, every lane address equals the base, and lane b of slice k holds element 16k+b.
- R6: A line request yields 4 beats, whatever its length. Let LB be the base with bits [2:0] cleared. Lane m (0 to 3) of beat j carries LB + (4j+m)*8, with mask bits 0 to 3 set. Mask bit 4 is set only on the fourth beat, and only when base bits [2:0] are non-zero; that lane then carries LB + 128. Mask bits 5 to 15 are always clear.
- R7: While `out_valid` is high and `out_ready` low, all beat outputs hold. While `gs_valid` is high and `gs_ready` low, the gather/scatter outputs hold.
- R8: `req_ready` is high only when no beat and no handoff is pending. A request is accepted only when `req_valid` and `req_ready` are both high at a clock edge.
- R9: During reset, `req_ready` is 1 and `out_valid` and `gs_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_base | input | 32 | Quadword base address |
| req_stride | input | 16 | Signed stride in quadwords |
| req_vl | input | 8 | Vector length, 0 to 128 |
| out_valid | output | 1 | Beat offered |
| out_ready | input | 1 | Beat taken when valid |
| out_addr | output | 512 | Sixteen 32-bit lane addresses, lane b at bits [32b+31:32b] |
| out_mask | output | 16 | Lane-valid mask |
| out_line | output | 1 | 1 for line beats, 0 for quadword slices |
| out_last | output | 1 | Final beat of the request |
| gs_valid | output | 1 | Request handed to gather/scatter |
| gs_ready | input | 1 | Gather/scatter path takes the request |
| gs_base | output | 32 | Forwarded base |
| gs_stride | output | 16 | Forwarded stride |
| gs_vl | output | 8 | Forwarded length |

## Verification
Length masking and bank reordering act on the same slice: when the length ends partway through a slice and the stride is odd but not one, the masked lanes are scattered across the beat rather than grouped at the top. Requests with such lengths and with strides like 3, 7 and negative odd values cause this. A behavioural model builds each expected slice element by element, placing each element on the lane of its own address. It compares every lane address and mask bit on every cycle, including cycles stalled by back-pressure.

// File: rtl/vslice_pkg.sv
package vslice_pkg;
    typedef enum logic [1:0] {
        CLS_SLICE,
        CLS_LINE,
        CLS_GATHER
    } stride_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SLICE,
        ST_LINE,
        ST_HANDOFF
    } gen_state_e;
endpackage

// File: rtl/vslice_classify.sv
module vslice_classify
    import vslice_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic [SW-1:0] stride,
    output stride_cls_e   cls
);
    logic is_zero;
    logic is_one;

    always_comb begin
        is_zero = (stride == '0);
        is_one  = (stride == SW'(1));
        if (is_one)
            cls = CLS_LINE;
        else if (is_zero || stride[0])
            cls = CLS_SLICE;
        else
            cls = CLS_GATHER;
    end
endmodule

// File: rtl/vslice_qword_lanes.sv
module vslice_qword_lanes #(
    parameter int AW      = 32,
    parameter int SW      = 16,
    parameter int LANES   = 16,
    parameter int SLICE_W = 3,
    parameter int VL_W    = 8
) (
    input  logic [AW-1:0]       base,
    input  logic [SW-1:0]       stride,
    input  logic [VL_W-1:0]     vl,
    input  logic [SLICE_W-1:0]  slice_idx,
    output logic [LANES*AW-1:0] addr,
    output logic [LANES-1:0]    mask
);
    localparam int BW    = $clog2(LANES);
    localparam int IDX_W = SLICE_W + BW;

    logic [BW-1:0] inv_w;
    logic          stride_zero;
    logic [AW-1:0] stride_ext;

    // inverse of the stride's low bits modulo the bank count (odd strides only)
    always_comb begin
        inv_w = '0;
        for (int c = 0; c < LANES; c++) begin
            if (BW'(c * int'(stride[BW-1:0])) == BW'(1))
                inv_w = BW'(c);
        end
    end

    assign stride_zero = (stride == '0);
    assign stride_ext  = {{(AW-SW){stride[SW-1]}}, stride};

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [BW-1:0]    diff;
        logic [BW-1:0]    pos;
        logic [IDX_W-1:0] elem;

        always_comb begin
            diff = BW'(b) - base[BW-1:0];
            pos  = stride_zero ? BW'(b) : BW'(diff * inv_w);
            elem = {slice_idx, pos};
        end

        assign addr[b*AW +: AW] = base + stride_ext * AW'(elem);
        assign mask[b]          = (VL_W'(elem) < vl);
    end
endmodule

// File: rtl/vslice_line_lanes.sv
module vslice_line_lanes #(
    parameter int AW         = 32,
    parameter int LANES      = 16,
    parameter int LINE_QW    = 8,
    parameter int UNIT_BEATS = 4,
    parameter int LPB        = 4,
    parameter int BEAT_W     = 2
) (
    input  logic [AW-1:0]       base,
    input  logic [BEAT_W-1:0]   beat_idx,
    output logic [LANES*AW-1:0] addr,
    output logic [LANES-1:0]    mask
);
    localparam int LINE_W = $clog2(LINE_QW);

    logic [AW-1:0] line_base;
    logic          misaligned;
    logic          final_beat;

    assign line_base  = {base[AW-1:LINE_W], {LINE_W{1'b0}}};
    assign misaligned = |base[LINE_W-1:0];
    assign final_beat = (beat_idx == BEAT_W'(UNIT_BEATS-1));

    for (genvar m = 0; m < LANES; m++) begin : g_lane
        if (m < LPB) begin : g_body
            assign addr[m*AW +: AW] = line_base + AW'((int'(beat_idx) * LPB + m) * LINE_QW);
            assign mask[m]          = 1'b1;
        end else if (m == LPB) begin : g_tail
            assign addr[m*AW +: AW] = line_base + AW'(UNIT_BEATS * LPB * LINE_QW);
            assign mask[m]          = final_beat && misaligned;
        end else begin : g_idle
            assign addr[m*AW +: AW] = '0;
            assign mask[m]          = 1'b0;
        end
    end
endmodule

// File: rtl/vslice_gen.sv
module vslice_gen
    import vslice_pkg::*;
#(
    parameter int AW         = 32,
    parameter int SW         = 16,
    parameter int LANES      = 16,
    parameter int MAX_VL     = 128,
    parameter int LINE_QW    = 8,
    parameter int UNIT_BEATS = 4,
    localparam int VL_W      = $clog2(MAX_VL + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [AW-1:0]       req_base,
    input  logic [SW-1:0]       req_stride,
    input  logic [VL_W-1:0]     req_vl,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [LANES*AW-1:0] out_addr,
    output logic [LANES-1:0]    out_mask,
    output logic                out_line,
    output logic                out_last,
    output logic                gs_valid,
    input  logic                gs_ready,
    output logic [AW-1:0]       gs_base,
    output logic [SW-1:0]       gs_stride,
    output logic [VL_W-1:0]     gs_vl
);
    localparam int BW      = $clog2(LANES);
    localparam int SLICES  = MAX_VL / LANES;
    localparam int SLICE_W = $clog2(SLICES);
    localparam int BEAT_W  = $clog2(UNIT_BEATS);
    localparam int LPB     = MAX_VL / (LINE_QW * UNIT_BEATS);

    gen_state_e    state_q, state_d;
    stride_cls_e   req_cls;
    logic [AW-1:0]      base_q;
    logic [SW-1:0]      stride_q;
    logic [VL_W-1:0]    vl_q;
    logic [SLICE_W-1:0] cnt_q;
    logic               accept;
    logic               beat_fire;

    logic [LANES*AW-1:0] qw_addr, ln_addr;
    logic [LANES-1:0]    qw_mask, ln_mask;

    vslice_classify #(.SW(SW)) u_classify (
        .stride (req_stride),
        .cls    (req_cls)
    );

    vslice_qword_lanes #(
        .AW(AW), .SW(SW), .LANES(LANES), .SLICE_W(SLICE_W), .VL_W(VL_W)
    ) u_qword (
        .base      (base_q),
        .stride    (stride_q),
        .vl        (vl_q),
        .slice_idx (cnt_q),
        .addr      (qw_addr),
        .mask      (qw_mask)
    );

    vslice_line_lanes #(
        .AW(AW), .LANES(LANES), .LINE_QW(LINE_QW), .UNIT_BEATS(UNIT_BEATS),
        .LPB(LPB), .BEAT_W(BEAT_W)
    ) u_line (
        .base     (base_q),
        .beat_idx (cnt_q[BEAT_W-1:0]),
        .addr     (ln_addr),
        .mask     (ln_mask)
    );

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign beat_fire = out_valid && out_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (req_cls)
                        CLS_SLICE: state_d = ST_SLICE;
                        CLS_LINE:  state_d = ST_LINE;
                        default:   state_d = ST_HANDOFF;
                    endcase
                end
            end
            ST_SLICE: begin
                if (out_ready && cnt_q == SLICE_W'(SLICES-1))
                    state_d = ST_IDLE;
            end
            ST_LINE: begin
                if (out_ready && cnt_q == SLICE_W'(UNIT_BEATS-1))
                    state_d = ST_IDLE;
            end
            ST_HANDOFF: begin
                if (gs_ready)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // request capture and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            stride_q <= '0;
            vl_q     <= '0;
            cnt_q    <= '0;
        end else if (accept) begin
            base_q   <= req_base;
            stride_q <= req_stride;
            vl_q     <= req_vl;
            cnt_q    <= '0;
        end else if (beat_fire) begin
            cnt_q    <= cnt_q + SLICE_W'(1);
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        out_valid = 1'b0;
        out_line  = 1'b0;
        out_last  = 1'b0;
        gs_valid  = 1'b0;
        out_addr  = qw_addr;
        out_mask  = qw_mask;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_SLICE: begin
                out_valid = 1'b1;
                out_last  = (cnt_q == SLICE_W'(SLICES-1));
            end
            ST_LINE: begin
                out_valid = 1'b1;
                out_line  = 1'b1;
                out_last  = (cnt_q == SLICE_W'(UNIT_BEATS-1));
                out_addr  = ln_addr;
                out_mask  = ln_mask;
            end
            ST_HANDOFF: gs_valid = 1'b1;
            default: req_ready = 1'b0;
        endcase
    end

    assign gs_base   = base_q;
    assign gs_stride = stride_q;
    assign gs_vl     = vl_q;

    // R1
    line_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_stride == SW'(1)) |=> (out_valid && out_line));

    // R1
    gather_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_stride != '0 && !req_stride[0]) |=> (gs_valid && !out_valid));

    // R2
    last_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> req_ready);

    // R7
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_mask) && $stable(out_last)));

    // R7
    gs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gs_valid && !gs_ready) |=> (gs_valid && $stable(gs_base) && $stable(gs_stride) && $stable(gs_vl)));

    // R8
    idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!out_valid && !gs_valid));

    // R6
    line_upper_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_line) |-> ((out_mask >> (LPB + 1)) == '0));

    for (genvar b = 0; b < LANES; b++) begin : g_bank_chk
        // R3
        lane_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_line && stride_q != '0) |-> (out_addr[b*AW +: BW] == BW'(b)));
    end
endmodule

// File: tb/vslice_gen_bench.sv
`timescale 1ns/1ps
module vslice_gen_bench;
    localparam int AW = 32;
    localparam int SW = 16;
    localparam int L  = 16;
    localparam int VW = 8;
    localparam int NREQ = 600;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [AW-1:0]   req_base = '0;
    logic [SW-1:0]   req_stride = '0;
    logic [VW-1:0]   req_vl = '0;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [L*AW-1:0] out_addr;
    logic [L-1:0]    out_mask;
    logic            out_line;
    logic            out_last;
    logic            gs_valid;
    logic            gs_ready = 1'b0;
    logic [AW-1:0]   gs_base;
    logic [SW-1:0]   gs_stride;
    logic [VW-1:0]   gs_vl;

    always #2.5 clk = ~clk;

    vslice_gen u_vslice_gen (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_stride(req_stride), .req_vl(req_vl),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_mask(out_mask),
        .out_line(out_line), .out_last(out_last),
        .gs_valid(gs_valid), .gs_ready(gs_ready),
        .gs_base(gs_base), .gs_stride(gs_stride), .gs_vl(gs_vl)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // expected beats
    logic [L*AW-1:0] eq_addr[$];
    logic [L-1:0]    eq_mask[$];
    bit              eq_line[$];
    bit              eq_last[$];
    string           eq_tag[$];
    bit              gs_pend = 0;
    logic [AW-1:0]   gs_e_base;
    logic [SW-1:0]   gs_e_stride;
    logic [VW-1:0]   gs_e_vl;

    task automatic chk(string tag, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_push(logic [AW-1:0] b, logic [SW-1:0] s, logic [VW-1:0] v);
        logic [L*AW-1:0] fa;
        logic [L-1:0]    fm;
        logic [AW-1:0]   lb;
        logic [AW-1:0]   a;
        int              sv;
        int              lane;
        if (s == SW'(1)) begin
            lb = {b[AW-1:3], 3'b000};
            for (int j = 0; j < 4; j++) begin
                fa = '0; fm = '0;
                for (int m = 0; m < 4; m++) begin
                    fa[m*AW +: AW] = lb + AW'((4*j + m) * 8);
                    fm[m] = 1'b1;
                end
                if (j == 3 && b[2:0] != 3'b000) begin
                    fa[4*AW +: AW] = lb + AW'(128);
                    fm[4] = 1'b1;
                end
                eq_addr.push_back(fa); eq_mask.push_back(fm);
                eq_line.push_back(1'b1); eq_last.push_back(j == 3); eq_tag.push_back("R6");
            end
        end else if (s == '0 || s[0]) begin
            sv = int'($signed(s));
            for (int k = 0; k < 8; k++) begin
                fa = '0; fm = '0;
                for (int i = 16*k; i < 16*k + 16; i++) begin
                    a = b + AW'(i * sv);
                    lane = (s == '0) ? (i % 16) : int'(a[3:0]);
                    fa[lane*AW +: AW] = a;
                    fm[lane] = (i < int'(v));
                end
                eq_addr.push_back(fa); eq_mask.push_back(fm);
                eq_line.push_back(1'b0); eq_last.push_back(k == 7);
                eq_tag.push_back((s == '0) ? "R5" : "R3");
            end
        end else begin
            gs_pend = 1; gs_e_base = b; gs_e_stride = s; gs_e_vl = v;
        end
    endtask

    task automatic pick_req(int n, output logic [AW-1:0] b, output logic [SW-1:0] s, output logic [VW-1:0] v);
        int kind;
        case (n)
            0: begin b = 32'h0000_0000; s = 16'd1;    v = 8'd128; end
            1: begin b = 32'h0000_0105; s = 16'd1;    v = 8'd3;   end
            2: begin b = 32'h0000_1000; s = 16'd3;    v = 8'd128; end
            3: begin b = 32'h0000_2007; s = 16'hFFFF; v = 8'd100; end
            4: begin b = 32'h0000_3333; s = 16'd0;    v = 8'd20;  end
            5: begin b = 32'h0000_0042; s = 16'd5;    v = 8'd0;   end
            6: begin b = 32'h0000_0010; s = 16'd2;    v = 8'd64;  end
            7: begin b = 32'h0000_0010; s = 16'd48;   v = 8'd9;   end
            8: begin b = 32'hFFFF_FFF0; s = 16'd7;    v = 8'd77;  end
            9: begin b = 32'h0000_5000; s = 16'd9;    v = 8'd17;  end
            default: begin
                b = $urandom;
                v = VW'($urandom_range(0, 128));
                kind = $urandom_range(0, 4);
                case (kind)
                    0: s = 16'd1;
                    1: s = 16'd0;
                    2: s = SW'($urandom) | 16'd1;
                    3: s = (SW'($urandom) & 16'hFFFE) | 16'd2;
                    default: s = SW'(-int'($urandom_range(0, 40)) * 2 - 1);
                endcase
            end
        endcase
    endtask

    initial begin
        bit   have_req = 0;
        int   sent = 0;
        int   cyc = 0;
        bit   acc, ofire;
        logic [AW-1:0] nb;
        logic [SW-1:0] ns;
        logic [VW-1:0] nv;

        repeat (3) @(negedge clk);
        chk("R9", "req_ready in reset", req_ready, 1);
        chk("R9", "out_valid in reset", out_valid, 0);
        chk("R9", "gs_valid in reset", gs_valid, 0);
        rst_n = 1'b1;

        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
                break;
            end
            // compare outputs with the model
            chk("R8", "req_ready", req_ready, (eq_addr.size() == 0 && !gs_pend));
            chk("R1", "out_valid", out_valid, (eq_addr.size() != 0));
            chk("R1", "gs_valid", gs_valid, gs_pend);
            if (eq_addr.size() != 0 && out_valid) begin
                chk(eq_tag[0] == "R6" ? "R6" : "R4", "out_mask", out_mask, eq_mask[0]);
                chk("R1", "out_line", out_line, eq_line[0]);
                chk(eq_tag[0] == "R6" ? "R6" : "R2", "out_last", out_last, eq_last[0]);
                for (int ln = 0; ln < L; ln++) begin
                    if (!eq_line[0] || eq_mask[0][ln])
                        chk(eq_tag[0], $sformatf("lane %0d addr", ln),
                            out_addr[ln*AW +: AW], eq_addr[0][ln*AW +: AW]);
                end
            end
            if (gs_pend && gs_valid) begin
                chk("R1", "gs_base", gs_base, gs_e_base);
                chk("R1", "gs_stride", gs_stride, gs_e_stride);
                chk("R1", "gs_vl", gs_vl, gs_e_vl);
            end
            if (sent >= NREQ && !have_req && eq_addr.size() == 0 && !gs_pend)
                break;
            // drive next cycle's inputs (R7 stalls come from random ready)
            out_ready = ($urandom_range(0, 3) != 0);
            gs_ready  = ($urandom_range(0, 2) == 0);
            if (!have_req && sent < NREQ) begin
                pick_req(sent, nb, ns, nv);
                req_base = nb; req_stride = ns; req_vl = nv;
                have_req = 1;
                sent++;
            end
            req_valid = have_req && ($urandom_range(0, 3) != 0);
            // advance the model to match the coming edge
            acc   = req_valid && (eq_addr.size() == 0 && !gs_pend);
            ofire = (eq_addr.size() != 0) && out_ready;
            if (ofire) begin
                void'(eq_addr.pop_front()); void'(eq_mask.pop_front());
                void'(eq_line.pop_front()); void'(eq_last.pop_front());
                void'(eq_tag.pop_front());
            end
            if (gs_pend && gs_ready) gs_pend = 0;
            if (acc) begin
                model_push(req_base, req_stride, req_vl);
                have_req = 0;
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule